// File: doc/BRIEF.md
# Three-Wire Serial Register and Memory Slave

This block is the slave side of a three-wire serial link. The wires are an active-low select, a serial clock driven by the host, and one data line that carries traffic in both directions. Through this link a host can write to and read from a 14-bit byte-addressed space on chip. That space holds registers and RAM, which sit outside this block behind a plain synchronous memory port.

A transfer opens with two address bytes. The first carries the read/write flag and the upper address bits, and the second carries the lower eight address bits. In write mode every further byte is stored, and the address steps up by one after each byte. In read mode the block fetches the addressed byte while the host waits, then takes over the data line and shifts bytes out, prefetching the next location while the current byte leaves. Raising select ends any transfer at once.

The serial pins are oversampled in the fast system clock domain through synchronizers. All edge detection happens on the synchronized copies.

Top module: `ser3_slave`

## Requirements
- R1: After reset the block is idle with the data-line output enable low. A falling select opens a transfer, and the first rising serial clock edge after that delivers bit 0 of the first byte.
- R2: A rising select returns the block to idle from any state. A byte that was only partly received is never written, and the next transfer starts cleanly.
- R3: The data line is sampled on rising serial clock edges. Every byte, whether address or data, travels least-significant bit first.
- R4: First byte: bit 7 is the read/write flag (0 = write, 1 = read), bits 5:0 are address bits 13:8, and bit 6 is ignored. The second byte gives address bits 7:0.
- R5: In write mode each complete data byte produces one write strobe at the current address, and the address then increments. The address wraps from 0x3FFF to 0x0000.
- R6: In read mode the bytes from consecutive addresses, wrapping at 0x3FFF, are shifted out LSB first. Each output bit changes only after a falling serial clock edge, so it stays stable while the clock is high.
- R7: The output enable stays low in idle, during both address bytes and in write mode. It is low again no more than two system clocks after select is high.
- R8: A host that waits 2 µs after the second address byte receives the byte at that address as its first read byte.
- R9: The memory port returns read data one system clock after a read strobe. Each read strobe is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selN | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from host |
| sdaIn | input | 1 | Data line as seen at the pad |
| sdaOut | output | 1 | Data line output value |
| sdaOe | output | 1 | Data line output enable |
| memAddr | output | 14 | Memory address |
| memWdata | output | 8 | Memory write data |
| memWe | output | 1 | Memory write strobe |
| memRe | output | 1 | Memory read strobe |
| memRdata | input | 8 | Memory read data, valid one clock after memRe |

## Verification
The assertions assume that select is held high for at least two system clocks before it falls, so that the synchronized select is high when any check depends on its history. They also assume that each serial clock phase lasts far longer than the synchronizer delay and the four-clock read fetch. The bench keeps each serial clock phase at ten system clocks and raises select only between transfers or on purpose to abort one. It lets the data line change only while the serial clock is low, and it waits the full 2 µs before the first read edge.

// File: rtl/ser3_pkg.sv
package ser3_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_AHI,
    ST_ALO,
    ST_WDATA,
    ST_RFETCH,
    ST_RLOAD,
    ST_RPRE,
    ST_RPCAP,
    ST_RDATA
  } ser3State_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;    // take one received bit
    logic latchHi;    // capture flag and upper address
    logic latchLo;    // capture lower address
    logic incAddr;    // step the address
    logic capTx;      // load transmit register from memory data
    logic capPre;     // load prefetch buffer from memory data
    logic txFromPre;  // move prefetch buffer into transmit register
    logic shiftOut;   // advance transmit register by one bit
  } ser3Strobe_t;

endpackage

// File: rtl/ser3_sync.sv
module ser3_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[g] <= RST_VAL;
        else       chain[g] <= din;
      end
    end else begin : gRest
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[g] <= RST_VAL;
        else       chain[g] <= chain[g-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/ser3_ctrl.sv
module ser3_ctrl
  import ser3_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        selSync,
  input  logic        sclkSync,
  input  logic        rwFlag,
  output ser3Strobe_t strobe,
  output logic        memWe,
  output logic        memRe,
  output logic        sdaOe
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  ser3State_t       state, nextState;
  logic [CNT_W-1:0] bitCnt;
  logic             byteDone;
  logic             sclkPrev;
  logic             sclkRise, sclkFall;
  logic             countState;

  assign sclkRise   = sclkSync & ~sclkPrev;
  assign sclkFall   = ~sclkSync & sclkPrev;
  assign countState = (state == ST_AHI) || (state == ST_ALO) ||
                      (state == ST_WDATA) || (state == ST_RDATA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b1;
    else       sclkPrev <= sclkSync;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    memWe     = 1'b0;
    memRe     = 1'b0;
    if (selSync) begin
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: nextState = ST_AHI;
        ST_AHI: if (sclkRise) begin
          strobe.shiftIn = 1'b1;
          if (bitCnt == LAST_BIT) begin
            strobe.latchHi = 1'b1;
            nextState      = ST_ALO;
          end
        end
        ST_ALO: if (sclkRise) begin
          strobe.shiftIn = 1'b1;
          if (bitCnt == LAST_BIT) begin
            strobe.latchLo = 1'b1;
            nextState      = rwFlag ? ST_RFETCH : ST_WDATA;
          end
        end
        ST_WDATA: if (sclkRise) begin
          strobe.shiftIn = 1'b1;
          if (bitCnt == LAST_BIT) begin
            memWe          = 1'b1;
            strobe.incAddr = 1'b1;
          end
        end
        ST_RFETCH: begin
          memRe     = 1'b1;
          nextState = ST_RLOAD;
        end
        ST_RLOAD: begin
          strobe.capTx   = 1'b1;
          strobe.incAddr = 1'b1;
          nextState      = ST_RPRE;
        end
        ST_RPRE: begin
          memRe     = 1'b1;
          nextState = ST_RPCAP;
        end
        ST_RPCAP: begin
          strobe.capPre  = 1'b1;
          strobe.incAddr = 1'b1;
          nextState      = ST_RDATA;
        end
        ST_RDATA: if (sclkFall) begin
          if (bitCnt != '0) begin
            strobe.shiftOut = 1'b1;
          end else if (byteDone) begin
            strobe.txFromPre = 1'b1;
            nextState        = ST_RPRE;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      byteDone <= 1'b0;
    end else begin
      state <= nextState;
      if (selSync || state == ST_IDLE) begin
        bitCnt   <= '0;
        byteDone <= 1'b0;
      end else begin
        if (sclkRise && countState) begin
          bitCnt <= bitCnt + 1'b1;
        end
        if (sclkRise && state == ST_RDATA && bitCnt == LAST_BIT) begin
          byteDone <= 1'b1;
        end else if (strobe.txFromPre) begin
          byteDone <= 1'b0;
        end
      end
    end
  end

  assign sdaOe = ~selSync && ((state == ST_RLOAD) || (state == ST_RPRE) ||
                              (state == ST_RPCAP) || (state == ST_RDATA));

  AST_ABORT_IDLE:    assert property (@(posedge clk) disable iff (!rstN)
                       selSync |=> state == ST_IDLE);                // R2
  AST_WE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
                       memWe |-> !rwFlag);                           // R5
  AST_OE_READ_ONLY:  assert property (@(posedge clk) disable iff (!rstN)
                       sdaOe |-> rwFlag);                            // R7
  AST_RE_PULSE:      assert property (@(posedge clk) disable iff (!rstN)
                       memRe |=> !memRe);                            // R9

endmodule

// File: rtl/ser3_dp.sv
module ser3_dp
  import ser3_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ser3Strobe_t       strobe,
  input  logic              sdaBit,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              rwFlag,
  output logic              sdaOut
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] rxShift, rxNext;
  logic [DATA_W-1:0] txShift, preBuf;
  logic [ADDR_W-1:0] addr;

  assign rxNext = {sdaBit, rxShift[DATA_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      preBuf  <= '0;
      addr    <= '0;
      rwFlag  <= 1'b0;
    end else begin
      if (strobe.shiftIn) rxShift <= rxNext;
      if (strobe.latchHi) begin
        rwFlag            <= rxNext[DATA_W-1];
        addr[ADDR_W-1:DATA_W] <= rxNext[HI_W-1:0];
      end else if (strobe.latchLo) begin
        addr[DATA_W-1:0] <= rxNext;
      end else if (strobe.incAddr) begin
        addr <= addr + 1'b1;
      end
      if (strobe.capTx)          txShift <= memRdata;
      else if (strobe.txFromPre) txShift <= preBuf;
      else if (strobe.shiftOut)  txShift <= {1'b0, txShift[DATA_W-1:1]};
      if (strobe.capPre) preBuf <= memRdata;
    end
  end

  assign memAddr  = addr;
  assign memWdata = rxNext;
  assign sdaOut   = txShift[0];

  AST_ONE_TX_LOAD: assert property (@(posedge clk) disable iff (!rstN)
                     !(strobe.capTx && strobe.shiftOut));            // R6

endmodule

// File: rtl/ser3_slave.sv
module ser3_slave
  import ser3_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              sclk,
  input  logic              sdaIn,
  output logic              sdaOut,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic              memRe,
  input  logic [DATA_W-1:0] memRdata
);

  logic [2:0]  pinSync;
  logic        rwFlag;
  ser3Strobe_t strobe;

  ser3_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) sync_i (
    .clk  (clk),
    .rstN (rstN),
    .din  ({selN, sclk, sdaIn}),
    .dout (pinSync)
  );

  ser3_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .selSync  (pinSync[2]),
    .sclkSync (pinSync[1]),
    .rwFlag   (rwFlag),
    .strobe   (strobe),
    .memWe    (memWe),
    .memRe    (memRe),
    .sdaOe    (sdaOe)
  );

  ser3_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sdaBit   (pinSync[0]),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .rwFlag   (rwFlag),
    .sdaOut   (sdaOut)
  );

  AST_OE_CLEAR:  assert property (@(posedge clk) disable iff (!rstN)
                   ($past(selN, 2) && $past(selN) && selN) |-> !sdaOe);   // R7
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
                   memWe |=> memAddr == ADDR_W'($past(memAddr) + 1'b1));  // R5

endmodule

// File: tb/ser3_slave_tb_top.sv
module ser3_slave_tb_top;

  localparam int HALF = 10;
  localparam int GAP  = 250;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        selN = 1'b1;
  logic        sclk = 1'b1;
  logic        hostSda = 1'b0;
  logic        sdaOut, sdaOe, memWe, memRe;
  logic [13:0] memAddr;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata = '0;
  logic        sdaLine;

  int tests = 0;
  int fails = 0;
  bit inWrite = 1'b0;
  bit finished = 1'b0;
  logic [7:0]  mem [int];
  logic [7:0]  shadow [int];
  logic [21:0] expQ [$];

  always #4 clk = ~clk;

  assign sdaLine = sdaOe ? sdaOut : hostSda;

  ser3_slave dut_i (
    .clk(clk), .rstN(rstN), .selN(selN), .sclk(sclk), .sdaIn(sdaLine),
    .sdaOut(sdaOut), .sdaOe(sdaOe), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .memRe(memRe), .memRdata(memRdata)
  );

  function automatic logic [7:0] pat(input logic [13:0] a);
    return a[7:0] ^ {2'b00, a[13:8]} ^ 8'h5A;
  endfunction

  // memory model: one clock read latency
  always @(posedge clk) begin
    if (memWe) mem[int'(memAddr)] = memWdata;
    if (memRe) memRdata <= mem.exists(int'(memAddr)) ? mem[int'(memAddr)] : pat(memAddr);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected writes as the design produces them
  always @(negedge clk) begin
    if (memWe) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R2 unexpected write", {10'd0, memAddr, memWdata}, 32'd0);
      end else begin
        logic [21:0] e;
        e = expQ.pop_front();
        chk({memAddr, memWdata} == e, "R5 write addr/data", {10'd0, memAddr, memWdata}, {10'd0, e});
      end
    end
    if (inWrite && sdaOe) chk(1'b0, "R7 oe during write", 32'd1, 32'd0);
  end

  task automatic sendByte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0;
      hostSda = b[i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic startXfer();
    @(negedge clk);
    selN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic stopXfer();
    selN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic writeBurst(input logic [13:0] a, input int n, input logic [7:0] base, input bit bit6);
    logic [13:0] cur;
    cur = a;
    inWrite = 1'b1;
    startXfer();
    sendByte({1'b0, bit6, a[13:8]});
    sendByte(a[7:0]);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = base + 8'(k * 37);
      expQ.push_back({cur, d});
      shadow[int'(cur)] = d;
      sendByte(d);
      cur = cur + 14'd1;
    end
    stopXfer();
    inWrite = 1'b0;
    chk(expQ.size() == 0, "R5 all writes seen", expQ.size(), 0);
  endtask

  function automatic logic [7:0] expRd(input logic [13:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : pat(a);
  endfunction

  task automatic readBurst(input logic [13:0] a, input int n, input bit keepSel);
    logic [13:0] cur;
    cur = a;
    startXfer();
    sendByte({1'b1, 1'b0, a[13:8]});
    chk(sdaOe == 1'b0, "R7 oe low in address phase", sdaOe, 0);
    sendByte(a[7:0]);
    hostSda = 1'b0;
    repeat (GAP) @(negedge clk);
    chk(sdaOe == 1'b1, "R6 oe high in read phase", sdaOe, 1);
    for (int k = 0; k < n; k++) begin
      logic [7:0] got;
      bit stableOk;
      stableOk = 1'b1;
      for (int i = 0; i < 8; i++) begin
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        got[i] = sdaLine;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        if (sdaLine !== got[i]) stableOk = 1'b0;
      end
      chk(stableOk, "R6 bit stable while clock high", 0, 0);
      chk(got == expRd(cur), (k == 0) ? "R8 first read byte" : "R6 burst read byte", got, expRd(cur));
      cur = cur + 14'd1;
    end
    if (!keepSel) stopXfer();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk(sdaOe == 1'b0 && memWe == 1'b0 && memRe == 1'b0, "R1 reset idle", {sdaOe, memWe, memRe}, 0);

    // R3 R4 R5: plain burst
    writeBurst(14'h1234, 3, 8'hA5, 1'b0);
    // R4: bit 6 set is ignored; R5: wrap past top
    writeBurst(14'h3FFE, 3, 8'h3C, 1'b1);
    // R6 R8: read back
    readBurst(14'h1234, 3, 1'b0);
    readBurst(14'h3FFF, 2, 1'b0);
    readBurst(14'h2000, 2, 1'b0);

    // R2: abort in the middle of a data byte
    inWrite = 1'b1;
    startXfer();
    sendByte(8'h12);
    sendByte(8'h34);
    for (int i = 0; i < 4; i++) begin
      sclk = 1'b0; hostSda = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    stopXfer();
    inWrite = 1'b0;
    chk(expQ.size() == 0, "R2 no write after abort", expQ.size(), 0);
    readBurst(14'h1234, 1, 1'b0);

    // R7: abort during read, oe cleared within two clocks
    readBurst(14'h0100, 1, 1'b1);
    chk(sdaOe == 1'b1, "R6 oe held while selected", sdaOe, 1);
    selN = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk(sdaOe == 1'b0, "R7 oe cleared after select high", sdaOe, 0);
    repeat (8) @(negedge clk);

    // R1 R2: fresh transfer after aborts
    writeBurst(14'h0A55, 2, 8'h11, 1'b0);
    readBurst(14'h0A55, 2, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule